// File: doc/BRIEF.md
# Dual-Clock Pixel Packet Buffer

This block sits between a pixel-producing application and a camera-serial transmit controller. The two sides run on unrelated clocks, and either clock may be the faster one. On the write side the application hands over a packet command, made of a data type, a virtual channel and a pixel count, through a request/acknowledge handshake. It then pushes wide pixel beats of IN_PIX pixels each. Each accepted command is tagged with a rolling sequence number, so a downstream stage can confirm that packets arrive in order.

On the read side the buffer offers a command to the controller only when enough pixel beats are already stored for the packet to stream without a gap. After the controller acknowledges, each read-enable strobe returns the next OUT_PIX pixels. The last word of a packet is marked, and the pixels in it that lie beyond the pixel count are zeroed. Commands and pixels cross the clock boundary through two separate dual-clock FIFOs that use Gray-coded pointers. A read strobe that finds no pixel data during a packet sets a sticky error flag.

Top module: `pix_pkt_buf`

## Requirements
- R1: When both resets are applied, tx_req, tx_dvalid, tx_last and rd_underrun are low and wr_ready is high.
- R2: A command is taken when wr_cmd_req and wr_ready are both high, and wr_cmd_ack is high in that same cycle. A pixel beat is taken when wr_pix_valid and wr_ready are both high. wr_ready is low while the pixel FIFO or the command FIFO is full, and wr_cmd_ack stays low during that time.
- R3: tx_req rises only once the pixel FIFO holds at least min(ceil(cnt/IN_PIX), RELEASE_TH) beats for the command at the head of the queue. While tx_req is high and tx_ack is low, tx_req stays high and tx_dt, tx_vc, tx_cnt and tx_seq keep the values of the command at the head of the queue.
- R4: After a tx_ack, each tx_rd_en returns the next OUT_PIX pixels on tx_data one rclk cycle later, with tx_dvalid high. Pixel k of a word sits in bits [k*PIX_W +: PIX_W], the earliest pixel in the lowest bits. Each input beat is split into IN_PIX/OUT_PIX words, lowest bits first.
- R5: The word that completes the pixel count has tx_last high. Its pixels at or beyond the count are zero. Any unused remainder of that input beat is discarded, so the next packet starts on a fresh beat.
- R6: Each accepted command carries a sequence number on tx_seq. The numbers start at 0 after reset, rise by one per command and wrap at 2^8.
- R7: A tx_rd_en outside a streaming packet, whether idle, waiting for tx_ack or after the last word, produces no tx_dvalid and does not advance the data.
- R8: A tx_rd_en during a packet while the pixel FIFO is empty produces no tx_dvalid and sets rd_underrun. rd_underrun stays high until rd_rst_n.
- R9: Packets come out in the order they were written, with intact data, whether wclk is faster or slower than rclk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-side (application) clock |
| wr_rst_n | input | 1 | Write-side synchronous reset, active low |
| wr_cmd_req | input | 1 | Packet command request |
| wr_cmd_dt | input | 6 | Command data type |
| wr_cmd_vc | input | 2 | Command virtual channel |
| wr_cmd_cnt | input | 12 | Command pixel count (at least 1) |
| wr_cmd_ack | output | 1 | Command taken this cycle |
| wr_pix_valid | input | 1 | Pixel beat valid |
| wr_pix_data | input | PIX_W*IN_PIX | Pixel beat, earliest pixel in low bits |
| wr_ready | output | 1 | Both FIFOs have room |
| rclk | input | 1 | Read-side (controller) clock |
| rd_rst_n | input | 1 | Read-side synchronous reset, active low |
| tx_req | output | 1 | Command offered to the controller |
| tx_dt | output | 6 | Offered data type |
| tx_vc | output | 2 | Offered virtual channel |
| tx_cnt | output | 12 | Offered pixel count |
| tx_seq | output | 8 | Offered sequence number |
| tx_ack | input | 1 | Controller accepts the offered command |
| tx_rd_en | input | 1 | Read strobe for the next pixel word |
| tx_data | output | PIX_W*OUT_PIX | Pixel word |
| tx_dvalid | output | 1 | tx_data holds a new word |
| tx_last | output | 1 | Word is the last of its packet |
| rd_underrun | output | 1 | Sticky empty-read error |

## Verification
Some properties are checked by assertions on every cycle. tx_req is never high without enough stored beats, and the offer is held until it is acknowledged. Neither FIFO is pushed when full or popped when empty. tx_last never appears without data, the underrun flag never clears, and the sequence number steps by one per accepted command. Other behaviour can only be shown by the bench scenarios: the actual pixel values and their order after width conversion, zero padding and remainder discard, strobes being ignored outside a packet, the back-pressure and underrun sequence on a packet larger than the FIFO, and packet order with the write clock faster and then slower than the read clock.

// File: rtl/pix_pkt_pkg.sv
`timescale 1ns/1ps
// Shared field widths, command record and read-side state encoding for the
// dual-clock pixel packet buffer.
package pix_pkt_pkg;
    localparam int DT_W  = 6;
    localparam int VC_W  = 2;
    localparam int CNT_W = 12;
    localparam int SEQ_W = 8;

    // One queued packet command, including its sequence tag.
    typedef struct packed {
        logic [DT_W-1:0]  dt;
        logic [VC_W-1:0]  vc;
        logic [CNT_W-1:0] cnt;
        logic [SEQ_W-1:0] seq;
    } pkt_cmd_t;

    localparam int CMD_W = DT_W + VC_W + CNT_W + SEQ_W;

    typedef enum logic [1:0] {
        S_IDLE   = 2'd0,
        S_REQ    = 2'd1,
        S_STREAM = 2'd2
    } rd_state_t;
endpackage

// File: rtl/pkt_sync.sv
`timescale 1ns/1ps
// Two-flop synchronizer for a Gray-coded pointer.
// Assumes: the input changes by at most one bit per source-clock edge.
module pkt_sync #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    // Capture stage followed by settle stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/pkt_afifo.sv
`timescale 1ns/1ps
// Dual-clock FIFO with Gray-coded pointers and 2^AW entries.
// The read side sees data and an occupancy count that lag writes by the
// synchronizer delay, which is conservative.
// Assumes: AW >= 2, each reset is held for a few cycles of both clocks.
module pkt_afifo #(
    parameter int W  = 32,
    parameter int AW = 4
) (
    input  logic          wclk,
    input  logic          wrst_n,
    input  logic          push,
    input  logic [W-1:0]  wdata,
    output logic          full,
    input  logic          rclk,
    input  logic          rrst_n,
    input  logic          pop,
    output logic [W-1:0]  rdata,
    output logic          empty,
    output logic [AW:0]   rcount
);
    localparam int DEPTH = 1 << AW;

    logic [W-1:0] mem [DEPTH];
    logic [AW:0]  wbin, wgray, rbin, rgray;
    logic [AW:0]  wbin_nx, rbin_nx;
    logic [AW:0]  rgray_w, wgray_r;

    function automatic logic [AW:0] gray2bin(input logic [AW:0] g);
        logic [AW:0] b;
        b[AW] = g[AW];
        for (int i = AW - 1; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction

    assign wbin_nx = wbin + 1'b1;
    assign rbin_nx = rbin + 1'b1;

    // Write pointer advance in binary and Gray form.
    always_ff @(posedge wclk) begin
        if (!wrst_n) begin
            wbin  <= '0;
            wgray <= '0;
        end else if (push && !full) begin
            wbin  <= wbin_nx;
            wgray <= wbin_nx ^ (wbin_nx >> 1);
        end
    end

    // Storage write.
    always_ff @(posedge wclk) begin
        if (push && !full) begin
            mem[wbin[AW-1:0]] <= wdata;
        end
    end

    // Read pointer advance in binary and Gray form.
    always_ff @(posedge rclk) begin
        if (!rrst_n) begin
            rbin  <= '0;
            rgray <= '0;
        end else if (pop && !empty) begin
            rbin  <= rbin_nx;
            rgray <= rbin_nx ^ (rbin_nx >> 1);
        end
    end

    pkt_sync #(.W(AW + 1)) u_sync_r2w (
        .clk   (wclk),
        .rst_n (wrst_n),
        .d     (rgray),
        .q     (rgray_w)
    );

    pkt_sync #(.W(AW + 1)) u_sync_w2r (
        .clk   (rclk),
        .rst_n (rrst_n),
        .d     (wgray),
        .q     (wgray_r)
    );

    assign full   = (wgray == {~rgray_w[AW:AW-1], rgray_w[AW-2:0]});
    assign empty  = (rgray == wgray_r);
    assign rcount = gray2bin(wgray_r) - rbin;
    assign rdata  = mem[rbin[AW-1:0]];

    // R2: the owner never pushes into a full FIFO.
    p_no_overflow_r2: assert property (@(posedge wclk) disable iff (!wrst_n)
        push |-> !full);

    // R8: the owner never pops an empty FIFO.
    p_no_underflow_r8: assert property (@(posedge rclk) disable iff (!rrst_n)
        pop |-> !empty);

    // R9: occupancy seen by the reader never exceeds the depth.
    p_count_bound_r9: assert property (@(posedge rclk) disable iff (!rrst_n)
        rcount <= (AW + 1)'(DEPTH));
endmodule

// File: rtl/pkt_rd_ctrl.sv
`timescale 1ns/1ps
// Read-side sequencer. It offers the head command once enough beats are
// stored, waits for the acknowledge, then slices each wide beat into narrow
// words on read strobes, zero-pads the final word and pops both queues.
// Assumes: IN_PIX is a power-of-two multiple of OUT_PIX, pixel count >= 1.
module pkt_rd_ctrl
    import pix_pkt_pkg::*;
#(
    parameter int PIX_W      = 16,
    parameter int IN_PIX     = 16,
    parameter int OUT_PIX    = 8,
    parameter int AW         = 4,
    parameter int RELEASE_TH = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cmd_empty,
    input  logic [CNT_W-1:0]         cmd_cnt,
    input  logic                     pix_empty,
    input  logic [AW:0]              pix_count,
    input  logic [PIX_W*IN_PIX-1:0]  pix_head,
    input  logic                     tx_ack,
    input  logic                     tx_rd_en,
    output logic                     cmd_pop,
    output logic                     pix_pop,
    output logic                     tx_req,
    output logic [PIX_W*OUT_PIX-1:0] tx_data,
    output logic                     tx_dvalid,
    output logic                     tx_last,
    output logic                     underrun
);
    localparam int OUT_W = PIX_W * OUT_PIX;
    localparam int RATIO = IN_PIX / OUT_PIX;
    localparam int SUB_W = (RATIO > 1) ? $clog2(RATIO) : 1;

    rd_state_t        st;
    logic [CNT_W-1:0] left;
    logic [SUB_W-1:0] sub;
    logic             data_ok, fire, is_last, end_of_beat;
    logic [OUT_W-1:0] slice, padded;
    int               need_beats, gate;

    // Beats required before the head command may be offered.
    always_comb begin
        need_beats = (int'(cmd_cnt) + IN_PIX - 1) / IN_PIX;
        gate       = (need_beats < RELEASE_TH) ? need_beats : RELEASE_TH;
        data_ok    = (int'(pix_count) >= gate);
    end

    assign fire        = (st == S_STREAM) && tx_rd_en && !pix_empty;
    assign is_last     = (left <= CNT_W'(OUT_PIX));
    assign end_of_beat = (sub == SUB_W'(RATIO - 1)) || is_last;
    assign pix_pop     = fire && end_of_beat;
    assign cmd_pop     = fire && is_last;
    assign tx_req      = (st == S_REQ);
    assign slice       = pix_head[int'(sub)*OUT_W +: OUT_W];

    // Zero every pixel lane at or beyond the remaining count.
    always_comb begin
        for (int k = 0; k < OUT_PIX; k++) begin
            padded[k*PIX_W +: PIX_W] = (CNT_W'(k) < left) ?
                slice[k*PIX_W +: PIX_W] : '0;
        end
    end

    // Packet sequencing, output word register and sticky underrun flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= S_IDLE;
            left      <= '0;
            sub       <= '0;
            tx_data   <= '0;
            tx_dvalid <= 1'b0;
            tx_last   <= 1'b0;
            underrun  <= 1'b0;
        end else begin
            tx_dvalid <= fire;
            tx_last   <= fire && is_last;
            if (fire) begin
                tx_data <= padded;
            end
            if ((st == S_STREAM) && tx_rd_en && pix_empty) begin
                underrun <= 1'b1;
            end
            case (st)
                S_IDLE: begin
                    if (!cmd_empty && data_ok) begin
                        st <= S_REQ;
                    end
                end
                S_REQ: begin
                    if (tx_ack) begin
                        st   <= S_STREAM;
                        left <= cmd_cnt;
                        sub  <= '0;
                    end
                end
                S_STREAM: begin
                    if (fire) begin
                        left <= left - CNT_W'(OUT_PIX);
                        sub  <= end_of_beat ? '0 : sub + 1'b1;
                        if (is_last) begin
                            st <= S_IDLE;
                        end
                    end
                end
                default: st <= S_IDLE;
            endcase
        end
    end

    // R3: an offer is only standing while enough beats are stored.
    p_req_gated_r3: assert property (@(posedge clk) disable iff (!rst_n)
        tx_req |-> data_ok);

    // R3: an unacknowledged offer is held.
    p_req_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_req && !tx_ack) |=> tx_req);

    // R5: a last marker always comes with data.
    p_last_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
        tx_last |-> tx_dvalid);

    // R7: no data follows a cycle outside streaming.
    p_idle_no_data_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st != S_STREAM) |=> !tx_dvalid);

    // R8: the underrun flag never clears on its own.
    p_underrun_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        underrun |=> underrun);
endmodule

// File: rtl/pix_pkt_buf.sv
`timescale 1ns/1ps
// Dual-clock pixel packet buffer. It queues tagged packet commands and wide
// pixel beats from the application clock domain and streams narrow words to
// a transmit controller in its own clock domain.
// Assumes: the application writes exactly ceil(cnt/IN_PIX) beats per
// command, in command order.
module pix_pkt_buf
    import pix_pkt_pkg::*;
#(
    parameter int PIX_W      = 16,
    parameter int IN_PIX     = 16,
    parameter int OUT_PIX    = 8,
    parameter int PIX_AW     = 4,
    parameter int CMD_AW     = 2,
    parameter int RELEASE_TH = 1 << PIX_AW
) (
    input  logic                     wclk,
    input  logic                     wr_rst_n,
    input  logic                     wr_cmd_req,
    input  logic [DT_W-1:0]          wr_cmd_dt,
    input  logic [VC_W-1:0]          wr_cmd_vc,
    input  logic [CNT_W-1:0]         wr_cmd_cnt,
    output logic                     wr_cmd_ack,
    input  logic                     wr_pix_valid,
    input  logic [PIX_W*IN_PIX-1:0]  wr_pix_data,
    output logic                     wr_ready,
    input  logic                     rclk,
    input  logic                     rd_rst_n,
    output logic                     tx_req,
    output logic [DT_W-1:0]          tx_dt,
    output logic [VC_W-1:0]          tx_vc,
    output logic [CNT_W-1:0]         tx_cnt,
    output logic [SEQ_W-1:0]         tx_seq,
    input  logic                     tx_ack,
    input  logic                     tx_rd_en,
    output logic [PIX_W*OUT_PIX-1:0] tx_data,
    output logic                     tx_dvalid,
    output logic                     tx_last,
    output logic                     rd_underrun
);
    localparam int IN_W = PIX_W * IN_PIX;

    logic [SEQ_W-1:0]  seq;
    logic              pix_full, cmd_full, pix_push;
    pkt_cmd_t          cmd_in, cmd_head;
    logic              cmd_empty, pix_empty, cmd_pop, pix_pop;
    logic [PIX_AW:0]   pix_count;
    logic [CMD_AW:0]   cmd_level;
    logic [IN_W-1:0]   pix_head;

    assign wr_ready   = !pix_full && !cmd_full;
    assign wr_cmd_ack = wr_cmd_req && wr_ready;
    assign pix_push   = wr_pix_valid && wr_ready;
    assign cmd_in     = '{dt: wr_cmd_dt, vc: wr_cmd_vc, cnt: wr_cmd_cnt, seq: seq};

    // Sequence tag counter, one step per accepted command.
    always_ff @(posedge wclk) begin
        if (!wr_rst_n) begin
            seq <= '0;
        end else if (wr_cmd_ack) begin
            seq <= seq + 1'b1;
        end
    end

    pkt_afifo #(.W(CMD_W), .AW(CMD_AW)) u_cmd_fifo (
        .wclk   (wclk),
        .wrst_n (wr_rst_n),
        .push   (wr_cmd_ack),
        .wdata  (cmd_in),
        .full   (cmd_full),
        .rclk   (rclk),
        .rrst_n (rd_rst_n),
        .pop    (cmd_pop),
        .rdata  (cmd_head),
        .empty  (cmd_empty),
        .rcount (cmd_level)
    );

    pkt_afifo #(.W(IN_W), .AW(PIX_AW)) u_pix_fifo (
        .wclk   (wclk),
        .wrst_n (wr_rst_n),
        .push   (pix_push),
        .wdata  (wr_pix_data),
        .full   (pix_full),
        .rclk   (rclk),
        .rrst_n (rd_rst_n),
        .pop    (pix_pop),
        .rdata  (pix_head),
        .empty  (pix_empty),
        .rcount (pix_count)
    );

    pkt_rd_ctrl #(
        .PIX_W      (PIX_W),
        .IN_PIX     (IN_PIX),
        .OUT_PIX    (OUT_PIX),
        .AW         (PIX_AW),
        .RELEASE_TH (RELEASE_TH)
    ) u_rd_ctrl (
        .clk       (rclk),
        .rst_n     (rd_rst_n),
        .cmd_empty (cmd_empty),
        .cmd_cnt   (cmd_head.cnt),
        .pix_empty (pix_empty),
        .pix_count (pix_count),
        .pix_head  (pix_head),
        .tx_ack    (tx_ack),
        .tx_rd_en  (tx_rd_en),
        .cmd_pop   (cmd_pop),
        .pix_pop   (pix_pop),
        .tx_req    (tx_req),
        .tx_data   (tx_data),
        .tx_dvalid (tx_dvalid),
        .tx_last   (tx_last),
        .underrun  (rd_underrun)
    );

    assign tx_dt  = cmd_head.dt;
    assign tx_vc  = cmd_head.vc;
    assign tx_cnt = cmd_head.cnt;
    assign tx_seq = cmd_head.seq;

    // R6: the tag advances by exactly one per accepted command.
    p_seq_step_r6: assert property (@(posedge wclk) disable iff (!wr_rst_n)
        wr_cmd_ack |=> (seq == $past(seq) + 1'b1));

    // R3: the offered fields stay put until acknowledged.
    p_fields_hold_r3: assert property (@(posedge rclk) disable iff (!rd_rst_n)
        (tx_req && !tx_ack) |=> $stable({tx_dt, tx_vc, tx_cnt, tx_seq}));

    // R9: a visible command always has a non-zero queue level.
    p_cmd_level_r9: assert property (@(posedge rclk) disable iff (!rd_rst_n)
        !cmd_empty |-> (cmd_level != '0));
endmodule

// File: tb/pix_pkt_buf_bench.sv
`timescale 1ns/1ps
module pix_pkt_buf_bench;
    localparam int PW = 16;
    localparam int IP = 16;
    localparam int OP = 8;

    logic wclk = 0, rclk = 0;
    real  wper = 6.0;
    logic wr_rst_n = 0, rd_rst_n = 0;
    logic wr_cmd_req = 0, wr_pix_valid = 0, tx_ack = 0, tx_rd_en = 0;
    logic [5:0]  wr_cmd_dt = 0;
    logic [1:0]  wr_cmd_vc = 0;
    logic [11:0] wr_cmd_cnt = 0;
    logic [PW*IP-1:0] wr_pix_data = '0;
    logic wr_cmd_ack, wr_ready, tx_req, tx_dvalid, tx_last, rd_underrun;
    logic [5:0]  tx_dt;
    logic [1:0]  tx_vc;
    logic [11:0] tx_cnt;
    logic [7:0]  tx_seq;
    logic [PW*OP-1:0] tx_data;

    int checks = 0, failures = 0;
    bit done = 0;

    pix_pkt_buf u_pix_pkt_buf (
        .wclk(wclk), .wr_rst_n(wr_rst_n), .wr_cmd_req(wr_cmd_req),
        .wr_cmd_dt(wr_cmd_dt), .wr_cmd_vc(wr_cmd_vc), .wr_cmd_cnt(wr_cmd_cnt),
        .wr_cmd_ack(wr_cmd_ack), .wr_pix_valid(wr_pix_valid),
        .wr_pix_data(wr_pix_data), .wr_ready(wr_ready), .rclk(rclk),
        .rd_rst_n(rd_rst_n), .tx_req(tx_req), .tx_dt(tx_dt), .tx_vc(tx_vc),
        .tx_cnt(tx_cnt), .tx_seq(tx_seq), .tx_ack(tx_ack), .tx_rd_en(tx_rd_en),
        .tx_data(tx_data), .tx_dvalid(tx_dvalid), .tx_last(tx_last),
        .rd_underrun(rd_underrun)
    );

    always #2 rclk = ~rclk;
    initial forever #(wper / 2.0) wclk = ~wclk;

    task automatic chk(input bit ok, input string req, input logic [127:0] act,
                       input logic [127:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [PW*IP-1:0] mk_beat(int p, int b);
        logic [PW*IP-1:0] v;
        for (int k = 0; k < IP; k++) begin
            int idx = b * IP + k;
            v[k*PW +: PW] = {8'(p), 8'(idx)};
        end
        return v;
    endfunction

    function automatic logic [PW*OP-1:0] exp_word(int p, int j, int cnt);
        logic [PW*OP-1:0] v;
        for (int k = 0; k < OP; k++) begin
            int idx = j * OP + k;
            v[k*PW +: PW] = (idx < cnt) ? {8'(p), 8'(idx)} : 16'h0;
        end
        return v;
    endfunction

    task automatic send_cmd(input int dt, input int vc, input int cnt);
        @(negedge wclk);
        while (!wr_ready) @(negedge wclk);
        wr_cmd_req = 1; wr_cmd_dt = 6'(dt); wr_cmd_vc = 2'(vc); wr_cmd_cnt = 12'(cnt);
        #0.1;
        chk(wr_cmd_ack === 1'b1, "R2 cmd ack", 128'(wr_cmd_ack), 128'(1));
        @(negedge wclk);
        wr_cmd_req = 0;
    endtask

    task automatic send_beat(input int p, input int b);
        @(negedge wclk);
        while (!wr_ready) @(negedge wclk);
        wr_pix_valid = 1; wr_pix_data = mk_beat(p, b);
        @(negedge wclk);
        wr_pix_valid = 0;
    endtask

    task automatic wait_req(input string req);
        int n = 0;
        @(negedge rclk);
        while (!tx_req && n < 3000) begin
            @(negedge rclk);
            n++;
        end
        chk(tx_req === 1'b1, req, 128'(tx_req), 128'(1));
    endtask

    task automatic do_ack();
        @(negedge rclk); tx_ack = 1;
        @(negedge rclk); tx_ack = 0;
    endtask

    task automatic rd_pulse();
        tx_rd_en = 1;
        @(negedge rclk);
        tx_rd_en = 0;
    endtask

    task automatic rd_check(input int p, input int j, input int cnt, input bit last);
        rd_pulse();
        chk(tx_dvalid === 1'b1, "R4 dvalid", 128'(tx_dvalid), 128'(1));
        chk(tx_data === exp_word(p, j, cnt), "R4/R5 data", tx_data, exp_word(p, j, cnt));
        chk(tx_last === last, "R5 last", 128'(tx_last), 128'(last));
    endtask

    task automatic read_pkt(input int p, input int dt, input int vc, input int cnt);
        int nw = (cnt + OP - 1) / OP;
        wait_req("R3 req");
        chk(tx_seq === 8'(p), "R6 seq", 128'(tx_seq), 128'(8'(p)));
        chk({tx_dt, tx_vc, tx_cnt} === {6'(dt), 2'(vc), 12'(cnt)}, "R9 fields",
            128'({tx_dt, tx_vc, tx_cnt}), 128'({6'(dt), 2'(vc), 12'(cnt)}));
        do_ack();
        for (int j = 0; j < nw; j++) rd_check(p, j, cnt, j == nw - 1);
    endtask

    task automatic t_reset();
        #0.1;
        chk(!tx_req && !tx_dvalid && !tx_last && !rd_underrun && wr_ready, "R1 reset",
            128'({tx_req, tx_dvalid, tx_last, rd_underrun, wr_ready}), 128'(5'b00001));
    endtask

    task automatic t_basic();
        send_cmd(6'h2b, 1, 32);
        repeat (20) @(negedge rclk);
        chk(tx_req === 1'b0, "R3 held back", 128'(tx_req), 128'(0));
        send_beat(0, 0);
        repeat (20) @(negedge rclk);
        chk(tx_req === 1'b0, "R3 partial", 128'(tx_req), 128'(0));
        send_beat(0, 1);
        read_pkt(0, 6'h2b, 1, 32);
    endtask

    task automatic t_odd();
        send_cmd(6'h1e, 2, 20);
        send_beat(1, 0); send_beat(1, 1);
        read_pkt(1, 6'h1e, 2, 20);
    endtask

    task automatic t_ignore();
        send_cmd(6'h12, 3, 16);
        send_beat(2, 0);
        wait_req("R3 req");
        @(negedge rclk);
        rd_pulse();
        chk(tx_dvalid === 1'b0, "R7 rd before ack", 128'(tx_dvalid), 128'(0));
        rd_pulse();
        chk(tx_req === 1'b1, "R7 req kept", 128'(tx_req), 128'(1));
        read_pkt(2, 6'h12, 3, 16);
        @(negedge rclk);
        rd_pulse();
        chk(tx_dvalid === 1'b0, "R7 rd after last", 128'(tx_dvalid), 128'(0));
    endtask

    task automatic t_fast_wr();
        wper = 3.0;
        send_cmd(6'h01, 0, 8);
        send_cmd(6'h02, 1, 40);
        send_cmd(6'h03, 2, 16);
        send_beat(3, 0);
        for (int b = 0; b < 3; b++) send_beat(4, b);
        send_beat(5, 0);
        read_pkt(3, 6'h01, 0, 8);
        read_pkt(4, 6'h02, 1, 40);
        read_pkt(5, 6'h03, 2, 16);
    endtask

    task automatic t_full_underrun();
        wper = 10.0;
        send_cmd(6'h3f, 3, 272);
        for (int b = 0; b < 16; b++) send_beat(6, b);
        repeat (3) @(negedge wclk);
        chk(wr_ready === 1'b0, "R2 ready low on full", 128'(wr_ready), 128'(0));
        wr_cmd_req = 1; #0.1;
        chk(wr_cmd_ack === 1'b0, "R2 no ack on full", 128'(wr_cmd_ack), 128'(0));
        @(negedge wclk); wr_cmd_req = 0;
        wait_req("R3 req at threshold");
        do_ack();
        for (int j = 0; j < 32; j++) rd_check(6, j, 272, 0);
        chk(rd_underrun === 1'b0, "R8 no underrun yet", 128'(rd_underrun), 128'(0));
        rd_pulse();
        chk(tx_dvalid === 1'b0, "R8 empty read", 128'(tx_dvalid), 128'(0));
        chk(rd_underrun === 1'b1, "R8 underrun set", 128'(rd_underrun), 128'(1));
        send_beat(6, 16);
        repeat (30) @(negedge rclk);
        rd_check(6, 32, 272, 0);
        rd_check(6, 33, 272, 1);
        chk(rd_underrun === 1'b1, "R8 sticky", 128'(rd_underrun), 128'(1));
    endtask

    initial begin
        repeat (10) @(posedge rclk);
        t_reset();
        @(negedge wclk); wr_rst_n = 1;
        @(negedge rclk); rd_rst_n = 1;
        repeat (5) @(negedge rclk);
        t_basic();
        t_odd();
        t_ignore();
        t_fast_wr();
        t_full_underrun();
        done = 1;
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < 150000) begin
            @(posedge rclk);
            cyc++;
        end
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=%0d expected=done", cyc);
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule